// File: doc/BRIEF.md
# SDRAM Single-Write Command Sequencer

This block performs one isolated write to a synchronous DRAM with a burst length of one. It takes a request (bank, row, column and one data word) over a valid/ready handshake. It opens the row, writes the word with auto-precharge disabled, and closes the bank with an explicit precharge. It then holds off further requests until the row cycle time has run out.

All spacing between commands comes from nanosecond parameters and a clock-period parameter. Each interval becomes a whole number of cycles: the ceiling of time divided by period, and never less than one. The write-to-precharge gap is lengthened whenever the minimum row-active time would otherwise be cut short.

The controller is a seven-state machine:

- `ST_IDLE`: ready is high. A valid request moves the machine to `ST_ACT`.
- `ST_ACT`: drives ACTIVE.
- `ST_RCD_WAIT`: waits until the write slot.
- `ST_WRITE`: drives WRITE.
- `ST_RECOVER`: waits until the precharge slot.
- `ST_PRECHARGE`: drives PRECHARGE.
- `ST_CLOSE_WAIT`: waits until the row cycle and precharge times have both elapsed, then returns to `ST_IDLE`.

Each state that issues a command jumps straight to the next command state when its slot is the very next cycle. Otherwise it goes through the wait state between them.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset, and in every cycle with no command, the command pins {cs_n, ras_n, cas_n, we_n} read 4'b0111 (NOP), dqm is high, dq_oe is low and req_ready is high. Only the codes 0111, 0011, 0100 and 0010 ever appear.
- R2: A request accepted on a clock edge (req_valid and req_ready both high) makes the next cycle an ACTIVE (4'b0011) with the request's bank on sdram_ba and its row on the low bits of sdram_addr.
- R3: The WRITE command (4'b0100) appears exactly N_RCD cycles after ACTIVE. Every cycle count N_x is max(1, ceil(T_x_PS / CLK_PS)).
- R4: In the WRITE cycle the address carries column bits 0..9 on A0..A9, A10 low, column bits 10 and up on A11 and up, and zeros above the column width. The data word is on sdram_dq_out with sdram_dq_oe high. dqm is low in that cycle and only in that cycle.
- R5: PRECHARGE (4'b0010) appears exactly max(N_RCD + N_WR, N_RAS) cycles after ACTIVE. It therefore honours both write recovery and minimum row-active time.
- R6: With PRE_ALL = 0 the precharge drives A10 low and puts the request's bank on sdram_ba. With PRE_ALL = 1 it drives A10 high and sdram_ba zero.
- R7: req_ready is low from the ACTIVE cycle until exactly max(P + N_RP, N_RC) cycles after ACTIVE, where P is the precharge offset of R5. It rises in that cycle, so successive ACTIVEs are at least N_RC apart and at least N_RP after the precharge.
- R8: While req_ready is low, req_valid and the request fields are ignored. No command is started, and the transaction in flight keeps the fields that were latched when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Column to write |
| req_data | input | DATA_W | Data word |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_ba | output | BANK_W | Bank address |
| sdram_addr | output | ADDR_W | Multiplexed row/column address |
| sdram_dq_out | output | DATA_W | Write data |
| sdram_dq_oe | output | 1 | Data output enable |
| sdram_dqm | output | 1 | Data mask, low only while writing |

## Verification
A state machine stuck in a wait state, or a cycle counter that is off by one, moves a command to the wrong cycle. The bench sees this on the next command after ACTIVE, since it compares every command offset against the cycle counts it computes itself. A wrong latch of the request shows up as mismatched bank, row, column or data on the very command that carries it. A machine that leaves idle early or late shows up on req_ready in the first cycle it differs from the expected close-out point. Three parameter sets cover a row-active-limited precharge, a recovery-limited precharge, and both precharge scopes.

// File: rtl/sdram_wr_pkg.sv
`timescale 1ns/1ps
package sdram_wr_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_RCD_WAIT,
        ST_WRITE,
        ST_RECOVER,
        ST_PRECHARGE,
        ST_CLOSE_WAIT
    } seq_state_e;

    // Interval in whole clock cycles, at least one.
    function automatic int unsigned to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_wr_timer.sv
`timescale 1ns/1ps
module sdram_wr_timer #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sdram_wr_fsm.sv
`timescale 1ns/1ps
module sdram_wr_fsm
    import sdram_wr_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned AT_WRITE = 2,
    parameter int unsigned AT_PRE   = 5,
    parameter int unsigned AT_NEXT  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] cnt,
    output seq_state_e       state,
    output logic             req_ready,
    output logic             accept,
    output logic             cnt_clr
);
    localparam logic [CNT_W-1:0] SLOT_WRITE = CNT_W'(AT_WRITE);
    localparam logic [CNT_W-1:0] SLOT_PRE   = CNT_W'(AT_PRE);
    localparam logic [CNT_W-1:0] SLOT_NEXT  = CNT_W'(AT_NEXT);

    seq_state_e       state_nxt;
    logic [CNT_W-1:0] cnt_ahead;

    assign cnt_ahead = cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) state_nxt = ST_ACT;
            end
            ST_ACT, ST_RCD_WAIT: begin
                state_nxt = (cnt_ahead == SLOT_WRITE) ? ST_WRITE : ST_RCD_WAIT;
            end
            ST_WRITE, ST_RECOVER: begin
                state_nxt = (cnt_ahead == SLOT_PRE) ? ST_PRECHARGE : ST_RECOVER;
            end
            ST_PRECHARGE, ST_CLOSE_WAIT: begin
                state_nxt = (cnt_ahead == SLOT_NEXT) ? ST_IDLE : ST_CLOSE_WAIT;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_ready && req_valid;
        cnt_clr   = (state == ST_IDLE);
    end
endmodule

// File: rtl/sdram_wr_pins.sv
`timescale 1ns/1ps
module sdram_wr_pins
    import sdram_wr_pkg::*;
#(
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned ROW_W   = 13,
    parameter int unsigned COL_W   = 11,
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned DATA_W  = 4,
    parameter bit          PRE_ALL = 1'b0
) (
    input  seq_state_e        state,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] data,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              dqm
);
    sdram_cmd_e        cmd;
    logic [ADDR_W-2:0] col_wide;
    logic [ADDR_W-1:0] col_addr;
    logic [ADDR_W-1:0] pre_addr;
    logic [BANK_W-1:0] pre_ba;

    // Column skips A10, which stays low so auto precharge is off.
    assign col_wide = (ADDR_W-1)'(col);
    assign col_addr = {col_wide[ADDR_W-2:10], 1'b0, col_wide[9:0]};

    generate
        if (PRE_ALL) begin : g_pre_all
            assign pre_addr = ADDR_W'(1) << 10;
            assign pre_ba   = '0;
        end else begin : g_pre_one
            assign pre_addr = '0;
            assign pre_ba   = bank;
        end
    endgenerate

    always_comb begin
        cmd    = CMD_NOP;
        ba     = '0;
        addr   = '0;
        dq_out = '0;
        dq_oe  = 1'b0;
        dqm    = 1'b1;
        unique case (state)
            ST_ACT: begin
                cmd  = CMD_ACT;
                ba   = bank;
                addr = ADDR_W'(row);
            end
            ST_WRITE: begin
                cmd    = CMD_WRITE;
                ba     = bank;
                addr   = col_addr;
                dq_out = data;
                dq_oe  = 1'b1;
                dqm    = 1'b0;
            end
            ST_PRECHARGE: begin
                cmd  = CMD_PRE;
                ba   = pre_ba;
                addr = pre_addr;
            end
            ST_IDLE, ST_RCD_WAIT, ST_RECOVER, ST_CLOSE_WAIT: begin
                cmd = CMD_NOP;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/sdram_wr_seq.sv
`timescale 1ns/1ps
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int unsigned CLK_PS   = 8000,
    parameter int unsigned T_RCD_PS = 15000,
    parameter int unsigned T_RAS_PS = 37000,
    parameter int unsigned T_RC_PS  = 60000,
    parameter int unsigned T_RP_PS  = 15000,
    parameter int unsigned T_WR_PS  = 14000,
    parameter int unsigned BANK_W   = 2,
    parameter int unsigned ROW_W    = 13,
    parameter int unsigned COL_W    = 11,
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned DATA_W   = 4,
    parameter bit          PRE_ALL  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_data,
    output logic              sdram_cs_n,
    output logic              sdram_ras_n,
    output logic              sdram_cas_n,
    output logic              sdram_we_n,
    output logic [BANK_W-1:0] sdram_ba,
    output logic [ADDR_W-1:0] sdram_addr,
    output logic [DATA_W-1:0] sdram_dq_out,
    output logic              sdram_dq_oe,
    output logic              sdram_dqm
);
    localparam int unsigned N_RCD   = to_cycles(T_RCD_PS, CLK_PS);
    localparam int unsigned N_RAS   = to_cycles(T_RAS_PS, CLK_PS);
    localparam int unsigned N_RC    = to_cycles(T_RC_PS,  CLK_PS);
    localparam int unsigned N_RP    = to_cycles(T_RP_PS,  CLK_PS);
    localparam int unsigned N_WR    = to_cycles(T_WR_PS,  CLK_PS);
    localparam int unsigned AT_PRE  = max_u(N_RCD + N_WR, N_RAS);
    localparam int unsigned AT_NEXT = max_u(AT_PRE + N_RP, N_RC);
    localparam int unsigned CNT_W   = $clog2(AT_NEXT + 1);

    seq_state_e        state;
    logic              accept;
    logic              cnt_clr;
    logic [CNT_W-1:0]  cnt;
    logic [BANK_W-1:0] hold_bank;
    logic [ROW_W-1:0]  hold_row;
    logic [COL_W-1:0]  hold_col;
    logic [DATA_W-1:0] hold_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_bank <= '0;
            hold_row  <= '0;
            hold_col  <= '0;
            hold_data <= '0;
        end else if (accept) begin
            hold_bank <= req_bank;
            hold_row  <= req_row;
            hold_col  <= req_col;
            hold_data <= req_data;
        end
    end

    sdram_wr_timer #(
        .CNT_W (CNT_W),
        .LIMIT (AT_NEXT)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    sdram_wr_fsm #(
        .CNT_W    (CNT_W),
        .AT_WRITE (N_RCD),
        .AT_PRE   (AT_PRE),
        .AT_NEXT  (AT_NEXT)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cnt       (cnt),
        .state     (state),
        .req_ready (req_ready),
        .accept    (accept),
        .cnt_clr   (cnt_clr)
    );

    sdram_wr_pins #(
        .BANK_W  (BANK_W),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PRE_ALL (PRE_ALL)
    ) pins_i (
        .state  (state),
        .bank   (hold_bank),
        .row    (hold_row),
        .col    (hold_col),
        .data   (hold_data),
        .cs_n   (sdram_cs_n),
        .ras_n  (sdram_ras_n),
        .cas_n  (sdram_cas_n),
        .we_n   (sdram_we_n),
        .ba     (sdram_ba),
        .addr   (sdram_addr),
        .dq_out (sdram_dq_out),
        .dq_oe  (sdram_dq_oe),
        .dqm    (sdram_dqm)
    );
endmodule

// File: rtl/sdram_wr_seq_chk.sv
`timescale 1ns/1ps
module sdram_wr_seq_chk #(
    parameter int unsigned N_RCD = 2,
    parameter int unsigned N_RAS = 5,
    parameter int unsigned N_RC  = 8,
    parameter int unsigned N_RP  = 2,
    parameter int unsigned N_WR  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10,
    input logic dq_oe,
    input logic dqm
);
    logic [3:0]  cmd;
    logic        is_act, is_wr, is_pre, is_nop;
    logic [15:0] since_act, since_wr, since_pre;
    logic        act_seen, wr_seen, pre_seen;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_act = (cmd == 4'b0011);
    assign is_wr  = (cmd == 4'b0100);
    assign is_pre = (cmd == 4'b0010);
    assign is_nop = (cmd == 4'b0111);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act <= '0;
            since_wr  <= '0;
            since_pre <= '0;
            act_seen  <= 1'b0;
            wr_seen   <= 1'b0;
            pre_seen  <= 1'b0;
        end else begin
            since_act <= is_act ? 16'd1 : ((since_act == 16'hFFFF) ? since_act : since_act + 16'd1);
            since_wr  <= is_wr  ? 16'd1 : ((since_wr  == 16'hFFFF) ? since_wr  : since_wr  + 16'd1);
            since_pre <= is_pre ? 16'd1 : ((since_pre == 16'hFFFF) ? since_pre : since_pre + 16'd1);
            if (is_act) act_seen <= 1'b1;
            if (is_wr)  wr_seen  <= 1'b1;
            if (is_pre) pre_seen <= 1'b1;
        end
    end

    // R1
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_act || is_wr || is_pre || is_nop);

    // R2
    accept_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> is_act);

    // R3
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> (act_seen && since_act >= N_RCD));

    // R4
    write_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> (!a10 && !dqm && dq_oe));

    // R4
    mask_outside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_wr |-> (dqm && !dq_oe));

    // R5
    ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (act_seen && since_act >= N_RAS));

    // R5
    wr_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (wr_seen && since_wr >= N_WR));

    // R7
    rc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && act_seen) |-> (since_act >= N_RC));

    // R7
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && pre_seen) |-> (since_pre >= N_RP));

    // R8
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> !req_ready);
endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(
    .N_RCD (N_RCD),
    .N_RAS (N_RAS),
    .N_RC  (N_RC),
    .N_RP  (N_RP),
    .N_WR  (N_WR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cs_n      (sdram_cs_n),
    .ras_n     (sdram_ras_n),
    .cas_n     (sdram_cas_n),
    .we_n      (sdram_we_n),
    .a10       (sdram_addr[10]),
    .dq_oe     (sdram_dq_oe),
    .dqm       (sdram_dqm)
);

// File: tb/sdram_wr_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_wr_lane #(
    parameter int unsigned CLK_PS   = 8000,
    parameter int unsigned T_RCD_PS = 15000,
    parameter int unsigned T_RAS_PS = 37000,
    parameter int unsigned T_RC_PS  = 60000,
    parameter int unsigned T_RP_PS  = 15000,
    parameter int unsigned T_WR_PS  = 14000,
    parameter int unsigned COL_W    = 11,
    parameter int unsigned DATA_W   = 4,
    parameter bit          PRE_ALL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic done
);
    function automatic int cyc(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_RCD  = cyc(T_RCD_PS, CLK_PS);
    localparam int E_RAS  = cyc(T_RAS_PS, CLK_PS);
    localparam int E_RC   = cyc(T_RC_PS,  CLK_PS);
    localparam int E_RP   = cyc(T_RP_PS,  CLK_PS);
    localparam int E_WR   = cyc(T_WR_PS,  CLK_PS);
    localparam int E_PRE  = (E_RCD + E_WR > E_RAS) ? E_RCD + E_WR : E_RAS;
    localparam int E_NEXT = (E_PRE + E_RP > E_RC) ? E_PRE + E_RP : E_RC;

    typedef struct {
        logic [1:0]        bank;
        logic [12:0]       row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
    } item_t;

    item_t exp_q[$];

    logic              req_valid;
    logic              req_ready;
    logic [1:0]        req_bank;
    logic [12:0]       req_row;
    logic [COL_W-1:0]  req_col;
    logic [DATA_W-1:0] req_data;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [1:0]        ba;
    logic [12:0]       addr;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;
    logic              dqm;

    sdram_wr_seq #(
        .CLK_PS   (CLK_PS),
        .T_RCD_PS (T_RCD_PS),
        .T_RAS_PS (T_RAS_PS),
        .T_RC_PS  (T_RC_PS),
        .T_RP_PS  (T_RP_PS),
        .T_WR_PS  (T_WR_PS),
        .BANK_W   (2),
        .ROW_W    (13),
        .COL_W    (COL_W),
        .ADDR_W   (13),
        .DATA_W   (DATA_W),
        .PRE_ALL  (PRE_ALL)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_data     (req_data),
        .sdram_cs_n   (cs_n),
        .sdram_ras_n  (ras_n),
        .sdram_cas_n  (cas_n),
        .sdram_we_n   (we_n),
        .sdram_ba     (ba),
        .sdram_addr   (addr),
        .sdram_dq_out (dq_out),
        .sdram_dq_oe  (dq_oe),
        .sdram_dqm    (dqm)
    );

    // Expected column placement per R4: A0..A9, A10 low, A11 upward.
    function automatic logic [12:0] col_map(input logic [COL_W-1:0] c);
        logic [11:0] p;
        p = 12'(c);
        return {p[11:10], 1'b0, p[9:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: optionally presents a junk request while busy (R8).
    task automatic send(input logic [1:0] b, input logic [12:0] r,
                        input logic [COL_W-1:0] c, input logic [DATA_W-1:0] d,
                        input bit junk);
        item_t it;
        if (junk) begin
            req_valid = 1'b1;
            req_bank  = ~b;
            req_row   = ~r;
            req_col   = ~c;
            req_data  = ~d;
        end
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        req_valid = 1'b1;
        req_bank  = b;
        req_row   = r;
        req_col   = c;
        req_data  = d;
        it.bank = b; it.row = r; it.col = c; it.data = d;
        exp_q.push_back(it);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        n_chk     = 0;
        n_fail    = 0;
        done      = 1'b0;
        req_valid = 1'b0;
        req_bank  = '0;
        req_row   = '0;
        req_col   = '0;
        req_data  = '0;
        @(posedge rst_n);
        repeat (2) @(negedge clk);
        send(2'd1, 13'h1ABC, {COL_W{1'b1}}, {DATA_W{1'b1}}, 1'b0);
        send(2'd2, 13'h0155, COL_W'(11'h2AA), DATA_W'(16'h5A3C), 1'b1);
        repeat (3) @(negedge clk);
        send(2'd3, 13'h1FFF, COL_W'(11'h401), DATA_W'(16'h1234), 1'b0);
        send(2'd0, 13'h0001, COL_W'(11'h0FF), DATA_W'(16'h8001), 1'b1);
        repeat (E_NEXT + 4) @(negedge clk);
        done = 1'b1;
    end

    // Monitor: sample pins at the falling edge.
    int  gcyc     = 0;
    int  since    = 0;
    bit  in_txn   = 1'b0;
    int  last_act = -1;
    int  last_pre = -1;
    bit  rst_seen = 1'b0;

    always @(negedge clk) begin
        logic [3:0] cmd;
        item_t      cur;
        if (rst_n) begin
            gcyc = gcyc + 1;
            cmd  = {cs_n, ras_n, cas_n, we_n};
            if (!rst_seen) begin
                rst_seen = 1'b1;
                check(cmd == 4'b0111, "R1", "reset cmd", cmd, 4'b0111);
                check(dqm && !dq_oe, "R1", "reset dqm/oe", {dqm, dq_oe}, 2'b10);
                check(req_ready, "R1", "reset ready", req_ready, 1);
            end
            if (in_txn) since = since + 1;
            if (exp_q.size() > 0) cur = exp_q[0];
            else begin
                cur.bank = '0; cur.row = '0; cur.col = '0; cur.data = '0;
            end
            unique case (cmd)
                4'b0011: begin
                    check(exp_q.size() > 0 && !in_txn, "R8", "ACTIVE without accepted request", in_txn, 0);
                    check(ba == cur.bank && addr == cur.row, "R2", "ACTIVE bank/row",
                          {ba, addr}, {cur.bank, cur.row});
                    if (last_act >= 0)
                        check(gcyc - last_act >= E_RC, "R7", "ACTIVE-to-ACTIVE gap", gcyc - last_act, E_RC);
                    if (last_pre >= 0)
                        check(gcyc - last_pre >= E_RP, "R7", "PRECHARGE-to-ACTIVE gap", gcyc - last_pre, E_RP);
                    check(!req_ready, "R7", "ready during ACTIVE", req_ready, 0);
                    last_act = gcyc;
                    since    = 0;
                    in_txn   = 1'b1;
                end
                4'b0100: begin
                    check(since == E_RCD, "R3", "WRITE offset", since, E_RCD);
                    check(addr == col_map(cur.col) && ba == cur.bank, "R4", "WRITE address",
                          {ba, addr}, {cur.bank, col_map(cur.col)});
                    check(dq_out == cur.data && dq_oe && !dqm, "R4", "WRITE data/mask",
                          {dq_out, dq_oe, dqm}, {cur.data, 1'b1, 1'b0});
                end
                4'b0010: begin
                    check(since == E_PRE, "R5", "PRECHARGE offset", since, E_PRE);
                    if (PRE_ALL)
                        check(addr[10] && ba == 2'd0, "R6", "PRECHARGE all scope",
                              {ba, addr[10]}, {2'd0, 1'b1});
                    else
                        check(!addr[10] && ba == cur.bank, "R6", "PRECHARGE bank scope",
                              {ba, addr[10]}, {cur.bank, 1'b0});
                    if (exp_q.size() > 0) void'(exp_q.pop_front());
                    last_pre = gcyc;
                end
                4'b0111: begin
                    if (!dqm || dq_oe)
                        check(1'b0, "R4", "mask outside WRITE", {dqm, dq_oe}, 2'b10);
                end
                default: check(1'b0, "R1", "illegal command code", cmd, 4'b0111);
            endcase
            if (in_txn && since > 0) begin
                if (since < E_NEXT) begin
                    if (req_ready) check(1'b0, "R7", "ready high too early", since, E_NEXT);
                end else begin
                    check(req_ready, "R7", "ready at close-out", req_ready, 1);
                    in_txn = 1'b0;
                end
            end
        end
    end
endmodule

module sdram_wr_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;

    always #4 clk = ~clk;

    int   a_chk, a_fail, b_chk, b_fail, c_chk, c_fail;
    logic a_done, b_done, c_done;

    // Fast grade, precharge limited by row-active time.
    sdram_wr_lane #(
        .CLK_PS (8000), .T_RCD_PS (15000), .T_RAS_PS (37000), .T_RC_PS (60000),
        .T_RP_PS (15000), .T_WR_PS (14000), .COL_W (11), .DATA_W (4), .PRE_ALL (1'b0)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .n_chk (a_chk), .n_fail (a_fail), .done (a_done)
    );

    // Slow grade, all-bank precharge.
    sdram_wr_lane #(
        .CLK_PS (8000), .T_RCD_PS (20000), .T_RAS_PS (44000), .T_RC_PS (66000),
        .T_RP_PS (20000), .T_WR_PS (15000), .COL_W (10), .DATA_W (8), .PRE_ALL (1'b1)
    ) lane_slow_i (
        .clk (clk), .rst_n (rst_n), .n_chk (b_chk), .n_fail (b_fail), .done (b_done)
    );

    // Long period, precharge limited by write recovery.
    sdram_wr_lane #(
        .CLK_PS (20000), .T_RCD_PS (15000), .T_RAS_PS (20000), .T_RC_PS (60000),
        .T_RP_PS (15000), .T_WR_PS (14000), .COL_W (9), .DATA_W (16), .PRE_ALL (1'b0)
    ) lane_long_i (
        .clk (clk), .rst_n (rst_n), .n_chk (c_chk), .n_fail (c_fail), .done (c_done)
    );

    initial begin
        int total;
        int failed;
        int cycles;
        cycles = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        while (!(a_done && b_done && c_done) && cycles < 20000) begin
            @(posedge clk);
            cycles = cycles + 1;
        end
        @(negedge clk);
        total  = a_chk + b_chk + c_chk;
        failed = a_fail + b_fail + c_fail;
        if (!(a_done && b_done && c_done)) begin
            total  = total + 1;
            failed = failed + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("  %0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule